// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the 8-bit arithmetic and logic stage of an accumulator-style processor. Each cycle in which `op_valid` is high, it reads an operation code, the accumulator, a second 8-bit operand and the current five-bit status byte. One clock edge later it presents the new accumulator value, the new status byte and a one-cycle accumulator write strike. It also performs a 16-bit register-pair addition into the HL pair. That addition gets its own result port and write strike, and it changes nothing in the status byte except carry.

Each operation has its own flag rule. Add and subtract families recompute every flag. Logical operations recompute sign, zero and parity and fix the two carries. The four rotates and the carry operations touch only carry. Complement touches no flag. Compare leaves the accumulator as it was. Decimal adjust reads both carries. Instruction fetch, decode and register-file addressing belong to the surrounding core.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, `acc_out`, `flags_out` and `hl_out` are zero, and `acc_we` and `hl_we` are low.
- R2: Results are registered. The outputs for an operation accepted with `op_valid` high show up after the next rising edge, and each write enable is high for that one cycle only. The status byte is laid out as bit 4 sign, bit 3 zero, bit 2 auxiliary carry, bit 1 parity, bit 0 carry. The operation codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 compare, 5 AND, 6 XOR, 7 OR, 8 rotate left, 9 rotate right, 10 rotate left through carry, 11 rotate right through carry, 12 complement, 13 set carry, 14 complement carry, 15 decimal adjust, 16 increment, 17 decrement, 18 pair add.
- R3: Add (code 0) and add with carry (code 1) write the 8-bit sum to the accumulator. Code 1 also adds the incoming carry. All five flags are recomputed: carry is the carry out of bit 7, auxiliary carry is the carry out of bit 3, and sign, zero and parity come from the sum.
- R4: Subtract (code 2) and subtract with borrow (code 3) write accumulator minus operand, and code 3 also subtracts the incoming carry. Carry is set when the subtraction borrows past bit 7. Auxiliary carry is set when it borrows out of bit 3. Sign, zero and parity come from the difference.
- R5: Compare (code 4) does not write the accumulator. It sets the flags the way code 2 would, so carry=1 when the accumulator is below the operand, zero=1 when they are equal, and both are 0 when the accumulator is greater.
- R6: AND (code 5) writes the bitwise AND, sets sign, zero and parity from it, clears carry and sets auxiliary carry.
- R7: XOR (code 6) and OR (code 7) write their result, set sign, zero and parity from it, and clear both carry and auxiliary carry.
- R8: Code 8 rotates left with bit 7 going to bit 0 and to carry. Code 9 rotates right with bit 0 going to bit 7 and to carry. Code 10 moves bit 7 into carry and the old carry into bit 0. Code 11 moves bit 0 into carry and the old carry into bit 7. Sign, zero, auxiliary carry and parity are left unchanged by all four.
- R9: Complement (code 12) writes the inverted accumulator and leaves all flags unchanged. Set carry (code 13) forces carry to 1. Complement carry (code 14) inverts carry. Codes 13 and 14 change no other flag and do not write the accumulator.
- R10: Decimal adjust (code 15) works in two steps. First, 6 is added when the low nibble is above 9 or auxiliary carry is set; auxiliary carry becomes the carry out of that low-nibble addition. Then 0x60 is added when the high nibble of the intermediate value is above 9, when carry is set, or when the first step overflowed bit 7; carry becomes 1 exactly when this second step is applied. Sign, zero and parity come from the final value.
- R11: Increment (code 16) and decrement (code 17) write the accumulator plus or minus one. They update sign, zero, parity and auxiliary carry (carry out of bit 3, or borrow out of bit 3) and keep carry as it was.
- R12: Pair add (code 18) writes `hl_in + pair_in` (modulo 2^16) to `hl_out` with a `hl_we` strike. Carry is set exactly when the sum exceeds 16 bits, the other four flags are unchanged, and the accumulator is not written.
- R13: Whenever an operation recomputes parity, the parity flag is 1 for an even number of one bits in the 8-bit result and 0 for an odd number.
- R14: With `op_valid` low, every output keeps its value and both write enables are low. An unused code (19 to 31) writes neither the accumulator nor HL, returns the accumulator unchanged on `acc_out`, and returns the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Accept the operation on this edge |
| op_sel | input | 5 | Operation code (see R2) |
| acc_in | input | 8 | Current accumulator value |
| operand | input | 8 | Second 8-bit operand |
| flags_in | input | 5 | Current status byte {S,Z,AC,P,CY} |
| hl_in | input | 16 | Current HL pair for the pair add |
| pair_in | input | 16 | Register pair added to HL |
| acc_out | output | 8 | New accumulator value |
| flags_out | output | 5 | New status byte {S,Z,AC,P,CY} |
| acc_we | output | 1 | One-cycle accumulator write strike |
| hl_out | output | 16 | New HL pair value |
| hl_we | output | 1 | One-cycle HL write strike |

## Verification
Every result has the same latency: one rising edge after the cycle in which `op_valid` is high. That covers the accumulator, the status byte, the HL sum and both write strikes. Every check therefore drives its inputs on a falling edge, drops `op_valid` at the next falling edge, and samples at that same falling edge, which comes half a period after the capturing edge. The latency check samples once before the capturing edge and once after it. It then looks one cycle later to confirm that the write enable has dropped. The hold checks confirm that the outputs stay unchanged over idle cycles even while the inputs change.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int PAIR_W = 2 * DATA_W;
  localparam int OP_W   = 5;
  localparam int FLAG_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_XOR = 5'd6,  OP_OR  = 5'd7,
    OP_RLC = 5'd8,  OP_RRC = 5'd9,  OP_RAL = 5'd10, OP_RAR = 5'd11,
    OP_CMA = 5'd12, OP_STC = 5'd13, OP_CMC = 5'd14, OP_DAA = 5'd15,
    OP_INC = 5'd16, OP_DEC = 5'd17, OP_DAD = 5'd18
  } alu_op_e;

  // Field order fixes the bit position: s=4 z=3 ac=2 p=1 cy=0
  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  typedef struct packed {
    logic [DATA_W-1:0] res;
    logic              ac;
    logic              cy;
  } arith_t;

  function automatic logic even_ones(input logic [DATA_W-1:0] v);
    return ~^v;
  endfunction

  function automatic flags_t mk_flags(input logic [DATA_W-1:0] r,
                                      input logic ac, input logic cy);
    flags_t f;
    f.s  = r[DATA_W-1];
    f.z  = (r == '0);
    f.ac = ac;
    f.p  = even_ones(r);
    f.cy = cy;
    return f;
  endfunction

  function automatic arith_t add8(input logic [DATA_W-1:0] a,
                                  input logic [DATA_W-1:0] b,
                                  input logic cin);
    arith_t o;
    logic [DATA_W:0] full;
    logic [NIB_W:0]  low;
    full  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    low   = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    o.res = full[DATA_W-1:0];
    o.cy  = full[DATA_W];
    o.ac  = low[NIB_W];
    return o;
  endfunction

  // borrow-style: cy/ac are 1 when the subtraction borrows past bit 7 / bit 3
  function automatic arith_t sub8(input logic [DATA_W-1:0] a,
                                  input logic [DATA_W-1:0] b,
                                  input logic bin);
    arith_t o;
    logic [DATA_W:0] full;
    logic [NIB_W:0]  low;
    full  = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, bin};
    low   = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, bin};
    o.res = full[DATA_W-1:0];
    o.cy  = full[DATA_W];
    o.ac  = low[NIB_W];
    return o;
  endfunction

  function automatic arith_t dec_adjust(input logic [DATA_W-1:0] a,
                                        input flags_t f);
    arith_t          o;
    logic            lo_fix;
    logic            hi_fix;
    logic [DATA_W:0] mid;
    logic [NIB_W:0]  lo_sum;
    lo_fix = (a[NIB_W-1:0] > NIB_W'(9)) | f.ac;
    mid    = {1'b0, a} + (lo_fix ? (DATA_W+1)'(6) : '0);
    lo_sum = {1'b0, a[NIB_W-1:0]} + (NIB_W+1)'(6);
    hi_fix = (mid[DATA_W-1:NIB_W] > NIB_W'(9)) | f.cy | mid[DATA_W];
    o.res  = mid[DATA_W-1:0] + (hi_fix ? DATA_W'(8'h60) : '0);
    o.ac   = lo_fix & lo_sum[NIB_W];
    o.cy   = hi_fix;
    return o;
  endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  flags_t            fin,
  output logic              hit,
  output logic              wr,
  output logic [DATA_W-1:0] res,
  output flags_t            fout
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  arith_t ar;
  logic   keep_cy;

  always_comb begin
    hit     = 1'b1;
    keep_cy = 1'b0;
    ar      = add8(a, b, 1'b0);
    unique case (op)
      OP_ADD:         ar = add8(a, b, 1'b0);
      OP_ADC:         ar = add8(a, b, fin.cy);
      OP_SUB, OP_CMP: ar = sub8(a, b, 1'b0);
      OP_SBB:         ar = sub8(a, b, fin.cy);
      OP_INC: begin   ar = add8(a, ONE, 1'b0); keep_cy = 1'b1; end
      OP_DEC: begin   ar = sub8(a, ONE, 1'b0); keep_cy = 1'b1; end
      default:        hit = 1'b0;
    endcase
  end

  always_comb begin
    res  = a;
    wr   = 1'b0;
    fout = fin;
    if (hit) begin
      wr   = (op != OP_CMP);
      res  = wr ? ar.res : a;
      fout = mk_flags(ar.res, ar.ac, keep_cy ? fin.cy : ar.cy);
    end
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  flags_t            fin,
  output logic              hit,
  output logic              wr,
  output logic [DATA_W-1:0] res,
  output flags_t            fout
);

  localparam int MSB = DATA_W - 1;

  always_comb begin
    hit  = 1'b1;
    wr   = 1'b1;
    res  = a;
    fout = fin;
    unique case (op)
      OP_AND: begin res = a & b; fout = mk_flags(res, 1'b1, 1'b0); end
      OP_XOR: begin res = a ^ b; fout = mk_flags(res, 1'b0, 1'b0); end
      OP_OR:  begin res = a | b; fout = mk_flags(res, 1'b0, 1'b0); end
      OP_RLC: begin res = {a[MSB-1:0], a[MSB]};  fout.cy = a[MSB]; end
      OP_RRC: begin res = {a[0], a[MSB:1]};      fout.cy = a[0];   end
      OP_RAL: begin res = {a[MSB-1:0], fin.cy};  fout.cy = a[MSB]; end
      OP_RAR: begin res = {fin.cy, a[MSB:1]};    fout.cy = a[0];   end
      OP_CMA: res = ~a;
      OP_STC: begin wr = 1'b0; fout.cy = 1'b1;    end
      OP_CMC: begin wr = 1'b0; fout.cy = ~fin.cy; end
      default: begin hit = 1'b0; wr = 1'b0; end
    endcase
  end

endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
  import alu8_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  flags_t            fin,
  output logic              hit,
  output logic              wr,
  output logic [DATA_W-1:0] res,
  output flags_t            fout
);

  arith_t da;

  always_comb begin
    hit  = (op == OP_DAA);
    wr   = hit;
    da   = dec_adjust(a, fin);
    res  = hit ? da.res : a;
    fout = hit ? mk_flags(da.res, da.ac, da.cy) : fin;
  end

endmodule

// File: rtl/alu8_pairadd.sv
module alu8_pairadd
  import alu8_pkg::*;
#(
  parameter int PW = PAIR_W
) (
  input  alu_op_e       op,
  input  logic [PW-1:0] hl,
  input  logic [PW-1:0] src,
  input  flags_t        fin,
  output logic          hit,
  output logic [PW-1:0] sum,
  output flags_t        fout
);

  logic [PW:0] wide;

  always_comb begin
    hit     = (op == OP_DAD);
    wide    = {1'b0, hl} + {1'b0, src};
    sum     = wide[PW-1:0];
    fout    = fin;
    fout.cy = wide[PW];
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu8_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] operand,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [PAIR_W-1:0] hl_in,
  input  logic [PAIR_W-1:0] pair_in,
  output logic [DATA_W-1:0] acc_out,
  output logic [FLAG_W-1:0] flags_out,
  output logic              acc_we,
  output logic [PAIR_W-1:0] hl_out,
  output logic              hl_we
);

  alu_op_e op;
  flags_t  fin;
  assign op  = alu_op_e'(op_sel);
  assign fin = flags_t'(flags_in);

  // per-unit claim, result, flags and write wires (named for the checks)
  logic              arith_hit, logic_hit, daa_hit, pair_hit;
  logic              arith_wr, logic_wr, daa_wr;
  logic [DATA_W-1:0] arith_res, logic_res, daa_res;
  flags_t            arith_f, logic_f, daa_f, pair_f;
  logic [PAIR_W-1:0] pair_sum;

  alu8_arith u_arith (
    .op(op), .a(acc_in), .b(operand), .fin(fin),
    .hit(arith_hit), .wr(arith_wr), .res(arith_res), .fout(arith_f)
  );

  alu8_logic u_logic (
    .op(op), .a(acc_in), .b(operand), .fin(fin),
    .hit(logic_hit), .wr(logic_wr), .res(logic_res), .fout(logic_f)
  );

  alu8_decadj u_daa (
    .op(op), .a(acc_in), .fin(fin),
    .hit(daa_hit), .wr(daa_wr), .res(daa_res), .fout(daa_f)
  );

  alu8_pairadd #(.PW(PAIR_W)) u_pair (
    .op(op), .hl(hl_in), .src(pair_in), .fin(fin),
    .hit(pair_hit), .sum(pair_sum), .fout(pair_f)
  );

  logic [DATA_W-1:0] nxt_acc;
  flags_t            nxt_flags;
  logic              nxt_acc_we;

  always_comb begin
    nxt_acc    = acc_in;
    nxt_flags  = fin;
    nxt_acc_we = 1'b0;
    if (arith_hit) begin
      nxt_acc = arith_res; nxt_flags = arith_f; nxt_acc_we = arith_wr;
    end else if (logic_hit) begin
      nxt_acc = logic_res; nxt_flags = logic_f; nxt_acc_we = logic_wr;
    end else if (daa_hit) begin
      nxt_acc = daa_res;   nxt_flags = daa_f;   nxt_acc_we = daa_wr;
    end else if (pair_hit) begin
      nxt_flags = pair_f;
    end
  end

  logic [DATA_W-1:0] acc_q;
  flags_t            flags_q;
  logic              acc_we_q, hl_we_q;
  logic [PAIR_W-1:0] hl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      flags_q  <= '0;
      acc_we_q <= 1'b0;
      hl_q     <= '0;
      hl_we_q  <= 1'b0;
    end else begin
      acc_we_q <= op_valid & nxt_acc_we;
      hl_we_q  <= op_valid & pair_hit;
      if (op_valid) begin
        acc_q   <= nxt_acc;
        flags_q <= nxt_flags;
        if (pair_hit) hl_q <= pair_sum;
      end
    end
  end

  assign acc_out   = acc_q;
  assign flags_out = flags_q;
  assign acc_we    = acc_we_q;
  assign hl_out    = hl_q;
  assign hl_we     = hl_we_q;

  // ---------------- assertions ----------------
  p_units_exclusive_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arith_hit, logic_hit, daa_hit, pair_hit}));

  p_idle_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !acc_we && !hl_we && $stable(acc_out) && $stable(flags_out));

  p_cmp_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OP_CMP |=> !acc_we && acc_out == $past(acc_in));

  p_and_carries_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OP_AND |=> flags_out[2] && !flags_out[0]);

  p_rotate_szap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op == OP_RLC || op == OP_RRC || op == OP_RAL || op == OP_RAR)
    |=> flags_out[4:1] == $past(flags_in[4:1]));

  p_incdec_cy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op == OP_INC || op == OP_DEC) |=> flags_out[0] == $past(flags_in[0]));

  p_pair_only_cy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OP_DAD
    |=> hl_we && !acc_we && flags_out[4:1] == $past(flags_in[4:1]));

  p_parity_even_r13: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op == OP_ADD || op == OP_OR) |=> flags_out[1] == ~^acc_out);

endmodule

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_sel = '0;
  logic [7:0]  acc_in = '0;
  logic [7:0]  operand = '0;
  logic [4:0]  flags_in = '0;
  logic [15:0] hl_in = '0;
  logic [15:0] pair_in = '0;
  logic [7:0]  acc_out;
  logic [4:0]  flags_out;
  logic        acc_we;
  logic [15:0] hl_out;
  logic        hl_we;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .acc_in(acc_in), .operand(operand), .flags_in(flags_in),
    .hl_in(hl_in), .pair_in(pair_in), .acc_out(acc_out),
    .flags_out(flags_out), .acc_we(acc_we), .hl_out(hl_out), .hl_we(hl_we)
  );

  // stimulus table: {op, acc, operand, flags {S,Z,AC,P,CY}}
  localparam int NV = 37;
  localparam logic [25:0] VEC [NV] = '{
    {5'd0,  8'h3A, 8'hC6, 5'b00000}, {5'd0,  8'h7F, 8'h01, 5'b00000},
    {5'd0,  8'h12, 8'h21, 5'b11111}, {5'd1,  8'hFF, 8'h00, 5'b00001},
    {5'd1,  8'h0E, 8'h01, 5'b00001}, {5'd2,  8'h05, 8'h07, 5'b00000},
    {5'd2,  8'h40, 8'h40, 5'b00001}, {5'd3,  8'h10, 8'h0F, 5'b00001},
    {5'd3,  8'h00, 8'hFF, 5'b00001}, {5'd4,  8'h20, 8'h30, 5'b00000},
    {5'd4,  8'h55, 8'h55, 5'b00001}, {5'd4,  8'h90, 8'h10, 5'b01001},
    {5'd5,  8'hF0, 8'h3C, 5'b00001}, {5'd5,  8'h0F, 8'hF0, 5'b00000},
    {5'd6,  8'h55, 8'h55, 5'b00101}, {5'd7,  8'h80, 8'h01, 5'b00101},
    {5'd8,  8'h81, 8'h00, 5'b11110}, {5'd9,  8'h01, 8'h00, 5'b00000},
    {5'd10, 8'h80, 8'h00, 5'b10100}, {5'd10, 8'h00, 8'h00, 5'b01011},
    {5'd11, 8'h01, 8'h00, 5'b00001}, {5'd11, 8'h02, 8'h00, 5'b11111},
    {5'd12, 8'h5A, 8'h00, 5'b10101}, {5'd13, 8'h12, 8'h00, 5'b01010},
    {5'd14, 8'h34, 8'h00, 5'b11111}, {5'd14, 8'h34, 8'h00, 5'b00000},
    {5'd15, 8'h9B, 8'h00, 5'b00000}, {5'd15, 8'h15, 8'h00, 5'b00100},
    {5'd15, 8'h99, 8'h00, 5'b00001}, {5'd15, 8'hFF, 8'h00, 5'b00000},
    {5'd15, 8'h00, 8'h00, 5'b00000}, {5'd16, 8'hFF, 8'h00, 5'b00001},
    {5'd16, 8'h0F, 8'h00, 5'b00000}, {5'd17, 8'h00, 8'h00, 5'b00000},
    {5'd17, 8'h10, 8'h00, 5'b00001}, {5'd25, 8'hA5, 8'h3C, 5'b10110},
    {5'd31, 8'h77, 8'h11, 5'b01001}
  };

  function automatic string req_of(input logic [4:0] op);
    case (op)
      5'd0, 5'd1:                   return "R3";
      5'd2, 5'd3:                   return "R4";
      5'd4:                         return "R5";
      5'd5:                         return "R6";
      5'd6, 5'd7:                   return "R7";
      5'd8, 5'd9, 5'd10, 5'd11:     return "R8";
      5'd12, 5'd13, 5'd14:          return "R9";
      5'd15:                        return "R10";
      5'd16, 5'd17:                 return "R11";
      5'd18:                        return "R12";
      default:                      return "R14";
    endcase
  endfunction

  function automatic logic even_count(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return (n % 2) == 0;
  endfunction

  function automatic logic [4:0] all_flags(input int r, input bit ac, input bit cy);
    return {r >= 128, r == 0, ac, even_count(r), cy};
  endfunction

  // reference model in plain integer arithmetic
  task automatic model(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [4:0] f, output logic [7:0] ea,
                       output logic [4:0] ef, output logic ew);
    int ia = a, ib = b, r;
    bit cyi = f[0], aci = f[2], nc, nac, fix_lo, fix_hi;
    ea = a; ef = f; ew = 1'b1;
    case (op)
      5'd0, 5'd1: begin
        int cin = (op == 5'd1) ? int'(cyi) : 0;
        r = ia + ib + cin; nc = r > 255; nac = (ia % 16 + ib % 16 + cin) > 15;
        r = r % 256; ea = 8'(r); ef = all_flags(r, nac, nc);
      end
      5'd2, 5'd3, 5'd4: begin
        int bin = (op == 5'd3) ? int'(cyi) : 0;
        r = ia - ib - bin; nc = r < 0; nac = (ia % 16 - ib % 16 - bin) < 0;
        r = (r + 512) % 256; ef = all_flags(r, nac, nc);
        if (op == 5'd4) ew = 1'b0; else ea = 8'(r);
      end
      5'd5: begin r = ia & ib; ea = 8'(r); ef = all_flags(r, 1'b1, 1'b0); end
      5'd6: begin r = ia ^ ib; ea = 8'(r); ef = all_flags(r, 1'b0, 1'b0); end
      5'd7: begin r = ia | ib; ea = 8'(r); ef = all_flags(r, 1'b0, 1'b0); end
      5'd8:  begin ea = 8'(((ia * 2) % 256) + ia / 128); ef[0] = a[7]; end
      5'd9:  begin ea = 8'(ia / 2 + (ia % 2) * 128);     ef[0] = a[0]; end
      5'd10: begin ea = 8'(((ia * 2) % 256) + int'(cyi)); ef[0] = a[7]; end
      5'd11: begin ea = 8'(ia / 2 + int'(cyi) * 128);     ef[0] = a[0]; end
      5'd12: ea = 8'(255 - ia);
      5'd13: begin ew = 1'b0; ef[0] = 1'b1; end
      5'd14: begin ew = 1'b0; ef[0] = !cyi; end
      5'd15: begin
        fix_lo = (ia % 16 > 9) || aci;
        r = ia + (fix_lo ? 6 : 0);
        nac = fix_lo && (ia % 16 + 6 > 15);
        fix_hi = ((r / 16) % 16 > 9) || cyi || (r > 255);
        r = (r + (fix_hi ? 96 : 0)) % 256;
        ea = 8'(r); ef = all_flags(r, nac, fix_hi);
      end
      5'd16: begin r = (ia + 1) % 256; ea = 8'(r); ef = all_flags(r, ia % 16 == 15, cyi); end
      5'd17: begin r = (ia + 255) % 256; ea = 8'(r); ef = all_flags(r, ia % 16 == 0, cyi); end
      default: ew = 1'b0;
    endcase
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive on a falling edge, capture on the rising edge, sample on the next falling edge
  task automatic issue(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [4:0] f, input logic [15:0] hl, input logic [15:0] pr);
    @(negedge clk);
    op_sel = op; acc_in = a; operand = b; flags_in = f; hl_in = hl; pair_in = pr;
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic run_vec(input logic [25:0] v);
    logic [4:0] op, f, ef;
    logic [7:0] a, b, ea;
    logic       ew;
    {op, a, b, f} = v;
    model(op, a, b, f, ea, ef, ew);
    issue(op, a, b, f, 16'h0, 16'h0);
    check({acc_out, flags_out, acc_we, hl_we} == {ea, ef, ew, 1'b0}, req_of(op),
          $sformatf("op %0d {acc,flags,we,hlwe}", op),
          {acc_out, flags_out, acc_we, hl_we}, {ea, ef, ew, 1'b0});
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] keep_acc;
    logic [4:0] keep_f;
    logic [15:0] keep_hl;
    // R1: outputs cleared while reset is held
    acc_in = 8'hFF; flags_in = 5'h1F; op_sel = 5'd0; op_valid = 1'b1;
    repeat (3) @(negedge clk);
    check({acc_out, flags_out, acc_we, hl_out, hl_we} == '0, "R1", "reset outputs",
          {acc_out, flags_out, acc_we, hl_out, hl_we}, 0);
    op_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: one-edge latency and one-cycle write strike
    op_sel = 5'd0; acc_in = 8'h11; operand = 8'h22; flags_in = 5'b0; op_valid = 1'b1;
    #1;
    check(acc_we == 1'b0 && acc_out == 8'h00, "R2", "before capture edge",
          {acc_we, acc_out}, 0);
    @(negedge clk); op_valid = 1'b0;
    check(acc_we == 1'b1 && acc_out == 8'h33, "R2", "after capture edge",
          {acc_we, acc_out}, {1'b1, 8'h33});
    @(negedge clk);
    check(acc_we == 1'b0, "R2", "strike lasts one cycle", acc_we, 0);

    // table walk R3..R11, R14 (unused codes)
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R13: parity even -> 1, odd -> 0
    issue(5'd7, 8'h03, 8'h00, 5'b0, 16'h0, 16'h0);
    check(flags_out[1] == 1'b1, "R13", "parity of 0x03", flags_out[1], 1);
    issue(5'd7, 8'h07, 8'h00, 5'b0, 16'h0, 16'h0);
    check(flags_out[1] == 1'b0, "R13", "parity of 0x07", flags_out[1], 0);

    // R12: pair add with and without overflow
    issue(5'd18, 8'h44, 8'h00, 5'b11110, 16'hFFFF, 16'h0001);
    check({hl_out, hl_we, acc_we, flags_out} == {16'h0000, 1'b1, 1'b0, 5'b11111},
          "R12", "pair add overflow", {hl_out, hl_we, acc_we, flags_out},
          {16'h0000, 1'b1, 1'b0, 5'b11111});
    issue(5'd18, 8'h44, 8'h00, 5'b01001, 16'h1234, 16'h1111);
    check({hl_out, hl_we, acc_we, flags_out} == {16'h2345, 1'b1, 1'b0, 5'b01000},
          "R12", "pair add no overflow", {hl_out, hl_we, acc_we, flags_out},
          {16'h2345, 1'b1, 1'b0, 5'b01000});
    @(negedge clk);
    check(hl_we == 1'b0, "R12", "hl strike lasts one cycle", hl_we, 0);

    // R14: idle cycles hold every output even with changing inputs
    issue(5'd6, 8'hC3, 8'h0F, 5'b0, 16'h0, 16'h0);
    keep_acc = acc_out; keep_f = flags_out; keep_hl = hl_out;
    op_sel = 5'd18; acc_in = 8'h01; operand = 8'h02; flags_in = 5'h1F;
    hl_in = 16'hAAAA; pair_in = 16'h5555;
    repeat (3) @(negedge clk);
    check({acc_out, flags_out, hl_out, acc_we, hl_we} == {keep_acc, keep_f, keep_hl, 2'b00},
          "R14", "idle hold", {acc_out, flags_out, hl_out, acc_we, hl_we},
          {keep_acc, keep_f, keep_hl, 2'b00});
    // R14: unused code leaves HL alone
    issue(5'd20, 8'h9C, 8'h00, 5'b10001, 16'h7777, 16'h1111);
    check({hl_out, hl_we, acc_out, flags_out} == {keep_hl, 1'b0, 8'h9C, 5'b10001},
          "R14", "unused code", {hl_out, hl_we, acc_out, flags_out},
          {keep_hl, 1'b0, 8'h9C, 5'b10001});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule